// File: doc/BRIEF.md
# Deep Idle Power-Down Sequencer

This controller belongs to one core. It moves that core into and out of its deepest idle level. When software asks for deep idle, the sequencer runs a fixed series of steps. It asks a helper to shrink the second-level cache, asks another helper to copy core state into a small retention memory, requests entry from the chipset, and waits for the chipset to confirm that the core clock is stopped and I/O is blocked. It then lowers the voltage-ID request. While the core is down, the chipset absorbs DMA snoops, so only the chipset's wake indication can start the exit.

The exit also runs in a fixed order. The sequencer pulses an internal reset, waits for the PLL to relock, asks for the saved state to be restored, asks for the cache to be re-expanded, and then pulses a resume strobe. The retention memory has ECC. An uncorrectable error reported while state is being restored stops the exit and raises a full-reset indication. Every wait for a helper or for the chipset is bounded by a programmable cycle limit. When a wait runs out, the sequencer returns to the active state and raises an error pulse.

An auto-demote heuristic counts reference ticks between successive wakes and keeps the most recent intervals. When their sum falls below the programmable threshold times the history depth, a new idle request goes to a shallower idle level. In that level the voltage ID stays up and no save is done. The current state code is visible on a status output.

Top module: `idle_pd_seq`

States and `state_o` codes: ACTIVE=0, FLUSH=1, SAVE=2, CS_ENTER=3, DEEP=4, RESET=5, RELOCK=6, RESTORE=7, EXPAND=8, RESUME=9, SHALLOW=10, FAIL=11.

Transitions:

| From | Condition | To |
|---|---|---|
| ACTIVE | `idle_req`, not demoted | FLUSH |
| ACTIVE | `idle_req`, demoted | SHALLOW |
| FLUSH | `flush_done` | SAVE |
| SAVE | `save_done` | CS_ENTER |
| CS_ENTER | `cs_ack` | DEEP |
| DEEP | `cs_wake` | RESET |
| RESET | always | RELOCK |
| RELOCK | `pll_lock` | RESTORE |
| RESTORE | `ecc_fatal` | FAIL |
| RESTORE | `restore_done` | EXPAND |
| EXPAND | `expand_done` | RESUME |
| RESUME | always | ACTIVE |
| SHALLOW | `cs_wake` | ACTIVE |
| any wait state | limit reached | ACTIVE |

## Requirements
- R1: After reset, `state_o` is 0 (ACTIVE) and every request, strobe and flag output is low.
- R2: A deep entry starts only when `idle_req` is seen in ACTIVE. It then goes FLUSH, SAVE, CS_ENTER, DEEP. Each step moves one cycle after its own completion input is seen, and a step stays put while that input is low.
- R3: `vid_low` is high only in DEEP. It rises one cycle after `cs_ack` is seen while `cs_enter_req` is high.
- R4: In DEEP, every input other than `cs_wake` has no effect: `idle_req`, the helper completion strobes and `ecc_fatal` leave the state at DEEP with `vid_low` high.
- R5: `cs_wake` in DEEP starts the exit: RESET for exactly one cycle with `core_rst` high, then RELOCK, RESTORE and EXPAND, each waiting on its own completion input, then RESUME for exactly one cycle with `resume` high, then ACTIVE.
- R6: `ecc_fatal` seen in RESTORE moves to FAIL, takes priority over `restore_done`, and holds `full_reset_ind` high until reset.
- R7: In a wait state (FLUSH, SAVE, CS_ENTER, RELOCK, RESTORE, EXPAND), when the wait reaches `wait_limit` cycles without completion, the sequencer spends `wait_limit`+1 cycles in that state, then returns to ACTIVE with `timeout_err` high for exactly that first ACTIVE cycle.
- R8: When the sum of the last `HIST_DEPTH` wake intervals is below `demote_thresh` × `HIST_DEPTH`, `idle_req` goes to SHALLOW. There `shallow_go` is high, no helper is requested, and `vid_low` stays low until `cs_wake` returns to ACTIVE. A threshold of 0 never demotes.
- R9: A wake interval is the number of `ref_tick` cycles between two accepted wakes (in DEEP or SHALLOW), saturating at its width. Reset fills the history with the maximum value. A single long interval can lift the demotion.
- R10: At most one of the six helper/chipset request outputs is high in any cycle, and each is high only in its own wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | Software request for the deepest idle level |
| ref_tick | input | 1 | Reference tick strobe for interval measurement |
| demote_thresh | input | IVL_W | Average wake interval below which idle is demoted |
| wait_limit | input | TO_W | Cycle limit for each handshake wait |
| flush_done | input | 1 | Cache shrink finished |
| save_done | input | 1 | State save finished |
| cs_ack | input | 1 | Chipset has stopped the clock and blocked I/O |
| cs_wake | input | 1 | Break event from chipset; regulator and bus clock restored |
| pll_lock | input | 1 | PLL relocked |
| restore_done | input | 1 | State restore finished |
| expand_done | input | 1 | Cache re-expanded |
| ecc_fatal | input | 1 | Uncorrectable error in retention memory during restore |
| flush_req | output | 1 | Request to shrink the cache |
| save_req | output | 1 | Request to save state |
| cs_enter_req | output | 1 | Request to the chipset for deep entry |
| vid_low | output | 1 | Voltage-ID request for power off |
| core_rst | output | 1 | Internal core reset pulse |
| pll_relock_req | output | 1 | Request to relock the PLL |
| restore_req | output | 1 | Request to restore state |
| expand_req | output | 1 | Request to re-expand the cache |
| resume | output | 1 | One-cycle strobe: continue at the next instruction |
| shallow_go | output | 1 | Core held in the demoted shallow idle level |
| full_reset_ind | output | 1 | Restore failed; full reset needed |
| timeout_err | output | 1 | One-cycle pulse after a handshake wait runs out |
| state_o | output | 4 | Current state code |

## Verification
The assertions check on every cycle that no two helper requests are high together, that the voltage-ID drop and the internal reset each follow their chipset handshake, that DEEP is left only on a wake, that the failure flag is sticky and caused only by an ECC error during restore, and that the timeout pulse lasts one cycle. What the bench scenarios alone can show is the full order of steps with their cycle counts, the exact length of a timeout, and the demotion decision. The demotion depends on several earlier wakes and on the tick count between them, so only a sequence of complete entries can show it switching on and then off again.

// File: rtl/idle_pd_pkg.sv
package idle_pd_pkg;
    typedef enum logic [3:0] {
        ST_ACTIVE   = 4'd0,
        ST_FLUSH    = 4'd1,
        ST_SAVE     = 4'd2,
        ST_CS_ENTER = 4'd3,
        ST_DEEP     = 4'd4,
        ST_RESET    = 4'd5,
        ST_RELOCK   = 4'd6,
        ST_RESTORE  = 4'd7,
        ST_EXPAND   = 4'd8,
        ST_RESUME   = 4'd9,
        ST_SHALLOW  = 4'd10,
        ST_FAIL     = 4'd11
    } pd_state_e;
endpackage

// File: rtl/idle_pd_timer.sv
module idle_pd_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            waiting,
    input  logic            restart,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] cnt_q;

    assign expired = waiting && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (restart || !waiting) cnt_q <= '0;
        else if (!expired)            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/idle_pd_demote.sv
module idle_pd_demote #(
    parameter int IVL_W      = 16,
    parameter int HIST_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             wake_evt,
    input  logic [IVL_W-1:0] thresh,
    output logic             demote
);
    localparam int LG    = $clog2(HIST_DEPTH);
    localparam int SUM_W = IVL_W + LG + 1;

    logic [IVL_W-1:0] ivl_q;
    logic [IVL_W-1:0] hist_q [HIST_DEPTH];
    logic [SUM_W-1:0] sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ivl_q <= '0;
        else if (wake_evt)                   ivl_q <= '0;
        else if (ref_tick && (ivl_q != '1))  ivl_q <= ivl_q + 1'b1;
    end

    generate
        for (genvar g = 0; g < HIST_DEPTH; g++) begin : g_hist
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        hist_q[g] <= '1;
                else if (wake_evt) begin
                    if (g == 0)    hist_q[g] <= ivl_q;
                    else           hist_q[g] <= hist_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_comb begin
        sum = '0;
        for (int i = 0; i < HIST_DEPTH; i++) sum = sum + SUM_W'(hist_q[i]);
    end

    assign demote = sum < (SUM_W'(thresh) << LG);
endmodule

// File: rtl/idle_pd_fsm.sv
module idle_pd_fsm
    import idle_pd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      idle_req,
    input  logic      demote,
    input  logic      flush_done,
    input  logic      save_done,
    input  logic      cs_ack,
    input  logic      cs_wake,
    input  logic      pll_lock,
    input  logic      restore_done,
    input  logic      expand_done,
    input  logic      ecc_fatal,
    input  logic      expired,
    output pd_state_e state_q,
    output logic      state_chg,
    output logic      waiting,
    output logic      wake_evt,
    output logic      timeout_q,
    output logic      flush_req,
    output logic      save_req,
    output logic      cs_enter_req,
    output logic      vid_low,
    output logic      core_rst,
    output logic      pll_relock_req,
    output logic      restore_req,
    output logic      expand_req,
    output logic      resume,
    output logic      shallow_go,
    output logic      full_reset_ind
);
    pd_state_e state_d;
    logic      to_hit;

    always_comb begin
        state_d = state_q;
        to_hit  = 1'b0;
        unique case (state_q)
            ST_ACTIVE:   if (idle_req) state_d = demote ? ST_SHALLOW : ST_FLUSH;
            ST_FLUSH:    if (flush_done) state_d = ST_SAVE;
                         else if (expired) begin state_d = ST_ACTIVE; to_hit = 1'b1; end
            ST_SAVE:     if (save_done) state_d = ST_CS_ENTER;
                         else if (expired) begin state_d = ST_ACTIVE; to_hit = 1'b1; end
            ST_CS_ENTER: if (cs_ack) state_d = ST_DEEP;
                         else if (expired) begin state_d = ST_ACTIVE; to_hit = 1'b1; end
            ST_DEEP:     if (cs_wake) state_d = ST_RESET;
            ST_RESET:    state_d = ST_RELOCK;
            ST_RELOCK:   if (pll_lock) state_d = ST_RESTORE;
                         else if (expired) begin state_d = ST_ACTIVE; to_hit = 1'b1; end
            ST_RESTORE:  if (ecc_fatal) state_d = ST_FAIL;
                         else if (restore_done) state_d = ST_EXPAND;
                         else if (expired) begin state_d = ST_ACTIVE; to_hit = 1'b1; end
            ST_EXPAND:   if (expand_done) state_d = ST_RESUME;
                         else if (expired) begin state_d = ST_ACTIVE; to_hit = 1'b1; end
            ST_RESUME:   state_d = ST_ACTIVE;
            ST_SHALLOW:  if (cs_wake) state_d = ST_ACTIVE;
            ST_FAIL:     state_d = ST_FAIL;
            default:     state_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_ACTIVE;
            timeout_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            timeout_q <= to_hit;
        end
    end

    always_comb begin
        flush_req      = (state_q == ST_FLUSH);
        save_req       = (state_q == ST_SAVE);
        cs_enter_req   = (state_q == ST_CS_ENTER);
        vid_low        = (state_q == ST_DEEP);
        core_rst       = (state_q == ST_RESET);
        pll_relock_req = (state_q == ST_RELOCK);
        restore_req    = (state_q == ST_RESTORE);
        expand_req     = (state_q == ST_EXPAND);
        resume         = (state_q == ST_RESUME);
        shallow_go     = (state_q == ST_SHALLOW);
        full_reset_ind = (state_q == ST_FAIL);
        waiting        = flush_req | save_req | cs_enter_req |
                         pll_relock_req | restore_req | expand_req;
        wake_evt       = cs_wake && (vid_low || shallow_go);
        state_chg      = (state_d != state_q);
    end
endmodule

// File: rtl/idle_pd_seq.sv
module idle_pd_seq
    import idle_pd_pkg::*;
#(
    parameter int IVL_W      = 16,
    parameter int HIST_DEPTH = 4,
    parameter int TO_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_req,
    input  logic             ref_tick,
    input  logic [IVL_W-1:0] demote_thresh,
    input  logic [TO_W-1:0]  wait_limit,
    input  logic             flush_done,
    input  logic             save_done,
    input  logic             cs_ack,
    input  logic             cs_wake,
    input  logic             pll_lock,
    input  logic             restore_done,
    input  logic             expand_done,
    input  logic             ecc_fatal,
    output logic             flush_req,
    output logic             save_req,
    output logic             cs_enter_req,
    output logic             vid_low,
    output logic             core_rst,
    output logic             pll_relock_req,
    output logic             restore_req,
    output logic             expand_req,
    output logic             resume,
    output logic             shallow_go,
    output logic             full_reset_ind,
    output logic             timeout_err,
    output logic [3:0]       state_o
);
    pd_state_e state_q;
    logic      state_chg, waiting, wake_evt, expired, demote;

    idle_pd_fsm i_fsm (
        .clk, .rst_n, .idle_req, .demote, .flush_done, .save_done, .cs_ack,
        .cs_wake, .pll_lock, .restore_done, .expand_done, .ecc_fatal, .expired,
        .state_q, .state_chg, .waiting, .wake_evt, .timeout_q(timeout_err),
        .flush_req, .save_req, .cs_enter_req, .vid_low, .core_rst,
        .pll_relock_req, .restore_req, .expand_req, .resume, .shallow_go,
        .full_reset_ind
    );

    idle_pd_timer #(.TO_W(TO_W)) i_timer (
        .clk, .rst_n, .waiting, .restart(state_chg), .limit(wait_limit), .expired
    );

    idle_pd_demote #(.IVL_W(IVL_W), .HIST_DEPTH(HIST_DEPTH)) i_demote (
        .clk, .rst_n, .ref_tick, .wake_evt, .thresh(demote_thresh), .demote
    );

    assign state_o = state_q;
endmodule

// File: rtl/idle_pd_seq_chk.sv
module idle_pd_seq_chk
    import idle_pd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       idle_req,
    input logic       cs_ack,
    input logic       cs_wake,
    input logic       expand_done,
    input logic       ecc_fatal,
    input logic       flush_req,
    input logic       save_req,
    input logic       cs_enter_req,
    input logic       vid_low,
    input logic       core_rst,
    input logic       pll_relock_req,
    input logic       restore_req,
    input logic       expand_req,
    input logic       resume,
    input logic       shallow_go,
    input logic       full_reset_ind,
    input logic       timeout_err,
    input logic [3:0] state_o
);
    p_entry_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> $past(idle_req));

    p_vid_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_low) |-> $past(cs_enter_req && cs_ack));

    p_deep_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_DEEP && !cs_wake) |=> (state_o == ST_DEEP));

    p_rst_after_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst) |-> $past(cs_wake && vid_low));

    p_rst_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> (!core_rst && pll_relock_req));

    p_resume_after_expand_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume) |-> $past(expand_req && expand_done));

    p_fail_from_ecc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_reset_ind) |-> $past(restore_req && ecc_fatal));

    p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full_reset_ind |=> full_reset_ind);

    p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> !timeout_err);

    p_err_to_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (state_o == ST_ACTIVE));

    p_shallow_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shallow_go) |-> $past(idle_req));

    p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_req, save_req, cs_enter_req, pll_relock_req, restore_req, expand_req}));
endmodule

bind idle_pd_seq idle_pd_seq_chk i_chk (
    .clk, .rst_n, .idle_req, .cs_ack, .cs_wake, .expand_done, .ecc_fatal,
    .flush_req, .save_req, .cs_enter_req, .vid_low, .core_rst, .pll_relock_req,
    .restore_req, .expand_req, .resume, .shallow_go, .full_reset_ind,
    .timeout_err, .state_o
);

// File: tb/test_idle_pd_seq.sv
module test_idle_pd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idle_req = 0, ref_tick = 0;
    logic [15:0] demote_thresh = '0;
    logic [15:0] wait_limit = 16'd1000;
    logic        flush_done = 0, save_done = 0, cs_ack = 0, cs_wake = 0;
    logic        pll_lock = 0, restore_done = 0, expand_done = 0, ecc_fatal = 0;
    logic        flush_req, save_req, cs_enter_req, vid_low, core_rst, pll_relock_req;
    logic        restore_req, expand_req, resume, shallow_go, full_reset_ind, timeout_err;
    logic [3:0]  state_o;
    int          checks = 0, errors = 0;

    always #2 clk = ~clk;

    idle_pd_seq i_idle_pd_seq (
        .clk, .rst_n, .idle_req, .ref_tick, .demote_thresh, .wait_limit,
        .flush_done, .save_done, .cs_ack, .cs_wake, .pll_lock, .restore_done,
        .expand_done, .ecc_fatal, .flush_req, .save_req, .cs_enter_req, .vid_low,
        .core_rst, .pll_relock_req, .restore_req, .expand_req, .resume,
        .shallow_go, .full_reset_ind, .timeout_err, .state_o
    );

    // request bus: {flush, save, cs_enter, relock, restore, expand}
    wire [5:0] reqs = {flush_req, save_req, cs_enter_req, pll_relock_req, restore_req, expand_req};
    wire [11:0] all_out = {reqs, vid_low, core_rst, resume, shallow_go, full_reset_ind, timeout_err};

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check("R1 state", state_o, 0);
        check("R1 outputs", all_out, 0);
    endtask

    task automatic t_no_req();
        // R2: completion strobes without idle_req do nothing
        flush_done = 1; save_done = 1; cs_ack = 1; pll_lock = 1;
        tick(); tick(); tick();
        flush_done = 0; save_done = 0; cs_ack = 0; pll_lock = 0;
        check("R2 stays active", state_o, 0);
    endtask

    // mode 0: normal, 1: noisy inputs in DEEP, 2: ECC error in restore
    task automatic deep_cycle(input int mode, input string etag);
        idle_req = 1; tick(); idle_req = 0;
        check(etag, state_o, 1);
        check("R10 flush only", reqs, 6'b100000);
        tick();
        check("R2 flush waits", state_o, 1);
        flush_done = 1; tick(); flush_done = 0;
        check("R2 save", state_o, 2);
        check("R10 save only", reqs, 6'b010000);
        save_done = 1; tick(); save_done = 0;
        check("R2 cs_enter", state_o, 3);
        check("R3 vid before ack", vid_low, 0);
        cs_ack = 1; tick(); cs_ack = 0;
        check("R2 deep", state_o, 4);
        check("R3 vid low", vid_low, 1);
        if (mode == 1) begin
            idle_req = 1; flush_done = 1; save_done = 1; pll_lock = 1;
            restore_done = 1; expand_done = 1; ecc_fatal = 1;
            for (int i = 0; i < 5; i++) tick();
            idle_req = 0; flush_done = 0; save_done = 0; pll_lock = 0;
            restore_done = 0; expand_done = 0; ecc_fatal = 0;
            check("R4 deep held", state_o, 4);
            check("R4 vid held", vid_low, 1);
        end
        cs_wake = 1; tick(); cs_wake = 0;
        check("R5 reset", state_o, 5);
        check("R5 core_rst", core_rst, 1);
        tick();
        check("R5 relock", state_o, 6);
        check("R5 reset one cycle", core_rst, 0);
        pll_lock = 1; tick(); pll_lock = 0;
        check("R5 restore", state_o, 7);
        if (mode == 2) begin
            ecc_fatal = 1; restore_done = 1; tick(); ecc_fatal = 0; restore_done = 0;
            check("R6 fail", state_o, 11);
            check("R6 full reset", full_reset_ind, 1);
            idle_req = 1; cs_wake = 1;
            tick(); tick(); tick();
            idle_req = 0; cs_wake = 0;
            check("R6 fail sticky", full_reset_ind, 1);
        end else begin
            restore_done = 1; tick(); restore_done = 0;
            check("R5 expand", state_o, 8);
            expand_done = 1; tick(); expand_done = 0;
            check("R5 resume", state_o, 9);
            check("R5 resume strobe", resume, 1);
            tick();
            check("R5 active", state_o, 0);
            check("R5 resume one cycle", resume, 0);
        end
    endtask

    task automatic t_timeout();
        wait_limit = 16'd5;
        idle_req = 1; tick(); idle_req = 0;
        for (int i = 0; i < 6; i++) begin
            check("R7 flush held", state_o, 1);
            tick();
        end
        check("R7 back to active", state_o, 0);
        check("R7 timeout pulse", timeout_err, 1);
        tick();
        check("R7 pulse one cycle", timeout_err, 0);
        wait_limit = 16'd1000;
    endtask

    task automatic t_demote();
        demote_thresh = 16'd10;
        ref_tick = 0;
        // R9: history starts at maximum, so four zero-length wakes are needed
        for (int k = 0; k < 4; k++) deep_cycle(0, "R9 deep before history fills");
        idle_req = 1; tick(); idle_req = 0;
        check("R8 demoted", state_o, 10);
        check("R8 shallow_go", shallow_go, 1);
        check("R8 no helper", reqs, 0);
        ref_tick = 1;
        for (int i = 0; i < 100; i++) tick();
        ref_tick = 0;
        check("R8 shallow held", state_o, 10);
        check("R8 vid stays up", vid_low, 0);
        cs_wake = 1; tick(); cs_wake = 0;
        check("R8 wake to active", state_o, 0);
        // R9: one interval of 100 ticks gives sum 100 >= 40
        deep_cycle(0, "R9 long interval lifts demote");
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick();
        t_reset();
        t_no_req();
        deep_cycle(0, "R2 entry to flush");
        deep_cycle(1, "R2 entry to flush");
        t_timeout();
        deep_cycle(2, "R2 entry to flush");
        t_reset();
        t_demote();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule